// File: doc/BRIEF.md
# Auxiliary Register Address Generator

This block forms the data-memory address for each access of a small fixed-point DSP datapath. It keeps eight pointer registers, a selector that names the current one, and a page register. In page mode the address is the page joined with an offset that comes with the instruction. In pointer mode the address is the current register's value. That register is then updated after use. It can step by one, step by the index held in register 0, or step by that index with the carry running from the top bit down, which walks bit-reversed FFT orders.

The address is combinational from state and inputs, so it is valid in the same cycle as the request. All updates land on the next rising edge: the post-modify, an explicit register load, a selector change and a page change. One request can name a new current register. The access still uses the old one, and the new one serves from the next cycle on.

Top module: `aux_addr_gen`

## Requirements
- R1: After reset all eight registers, the selector and the page are zero.
- R2: With `ar_wr` high, register `ar_wr_sel` takes `ar_wr_data` at the next edge; `ar_rd_data` always shows register `ar_rd_sel`.
- R3: With `op_direct` high, `ea` = {page, offset_in}, where the page occupies the upper 9 bits. A page write (`page_wr`) in the same cycle affects only later accesses.
- R4: Modify code 0 (or 7) in pointer mode gives `ea` = current register and leaves that register unchanged.
- R5: Codes 1 and 2 give `ea` = current register, then add or subtract one.
- R6: Codes 3 and 4 give `ea` = current register, then add or subtract register 0. When register 0 is itself current, its old value is the step.
- R7: Codes 5 and 6 give `ea` = current register, then add or subtract register 0 with the carry or borrow travelling from bit 15 toward bit 0.
- R8: `ptr_wr` loads `ptr_val` into the selector at the next edge. An access in the same cycle uses the old selector.
- R9: When an explicit load targets the register being post-modified in the same cycle, the load wins. A load to any other register happens alongside the modify.
- R10: All stepping wraps modulo 2^16, with no flag.
- R11: A page-mode access or an idle cycle leaves every register unchanged, whatever the modify code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | An access happens this cycle |
| op_direct | input | 1 | 1 = page mode, 0 = pointer mode |
| mod_code | input | 3 | Post-modify code (R4 to R7) |
| offset_in | input | 7 | Word offset within the page |
| ptr_wr | input | 1 | Load the selector |
| ptr_val | input | 3 | New selector value |
| page_wr | input | 1 | Load the page register |
| page_val | input | 9 | New page value |
| ar_wr | input | 1 | Load a pointer register |
| ar_wr_sel | input | 3 | Register to load |
| ar_wr_data | input | 16 | Load value |
| ar_rd_sel | input | 3 | Register to read |
| ar_rd_data | output | 16 | Read value |
| ea | output | 16 | Effective address |

## Verification
Two updates can land in the same cycle: the post-modify of the current register and an explicit load to a register, or an access together with a selector or page change. The bench provokes these by issuing a step and a load to the same register in one cycle, and also to different registers. It also issues an access together with a new selector or page. A scoreboard model judges the result: it checks that the load overrode the step, that both updates landed when the targets differed, and that the access used the old selector and old page while the next cycle used the new ones.

// File: rtl/agen_pkg.sv
package agen_pkg;
    typedef enum logic [2:0] {
        MOD_NONE   = 3'd0,
        MOD_INC1   = 3'd1,
        MOD_DEC1   = 3'd2,
        MOD_INC_IX = 3'd3,
        MOD_DEC_IX = 3'd4,
        MOD_INC_RC = 3'd5,
        MOD_DEC_RC = 3'd6,
        MOD_RSVD   = 3'd7
    } mod_e;
endpackage

// File: rtl/agen_rcadd.sv
module agen_rcadd #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] y
);
    logic [W-1:0] ra;
    logic [W-1:0] rb;
    logic [W-1:0] rs;

    for (genvar i = 0; i < W; i++) begin : g_mirror
        assign ra[i] = a[W-1-i];
        assign rb[i] = b[W-1-i];
        assign y[i]  = rs[W-1-i];
    end

    assign rs = sub ? (ra - rb) : (ra + rb);

    // R7: a zero step leaves the operand untouched in both directions
    always_comb begin
        p_rc_zero_r7: assert (b != '0 || y == a);
    end
endmodule

// File: rtl/agen_postmod.sv
module agen_postmod
    import agen_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] idx,
    input  mod_e         mode,
    output logic [W-1:0] nxt
);
    logic [W-1:0] rc_y;

    agen_rcadd #(.W(W)) u_rc (
        .a   (cur),
        .b   (idx),
        .sub (mode == MOD_DEC_RC),
        .y   (rc_y)
    );

    always_comb begin
        case (mode)
            MOD_INC1:   nxt = cur + W'(1);
            MOD_DEC1:   nxt = cur - W'(1);
            MOD_INC_IX: nxt = cur + idx;
            MOD_DEC_IX: nxt = cur - idx;
            MOD_INC_RC,
            MOD_DEC_RC: nxt = rc_y;
            default:    nxt = cur;
        endcase
    end
endmodule

// File: rtl/aux_addr_gen.sv
module aux_addr_gen
    import agen_pkg::*;
#(
    parameter int W      = 16,
    parameter int NREG   = 8,
    parameter int PAGE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    op_valid,
    input  logic                    op_direct,
    input  logic [2:0]              mod_code,
    input  logic [W-PAGE_W-1:0]     offset_in,
    input  logic                    ptr_wr,
    input  logic [$clog2(NREG)-1:0] ptr_val,
    input  logic                    page_wr,
    input  logic [PAGE_W-1:0]       page_val,
    input  logic                    ar_wr,
    input  logic [$clog2(NREG)-1:0] ar_wr_sel,
    input  logic [W-1:0]            ar_wr_data,
    input  logic [$clog2(NREG)-1:0] ar_rd_sel,
    output logic [W-1:0]            ar_rd_data,
    output logic [W-1:0]            ea
);
    localparam int PTR_W = $clog2(NREG);
    localparam int OFF_W = W - PAGE_W;

    typedef struct packed {
        logic [NREG-1:0][W-1:0] ar;
        logic [PTR_W-1:0]       ptr;
        logic [PAGE_W-1:0]      page;
    } state_t;

    state_t       s_d, s_q;
    logic [W-1:0] cur_w;
    logic [W-1:0] nxt_w;
    logic         mod_en;

    assign cur_w  = s_q.ar[s_q.ptr];
    assign mod_en = op_valid && !op_direct;

    agen_postmod #(.W(W)) u_pm (
        .cur  (cur_w),
        .idx  (s_q.ar[0]),
        .mode (mod_e'(mod_code)),
        .nxt  (nxt_w)
    );

    always_comb begin
        s_d = s_q;
        if (mod_en)  s_d.ar[s_q.ptr]  = nxt_w;
        if (ar_wr)   s_d.ar[ar_wr_sel] = ar_wr_data;
        if (ptr_wr)  s_d.ptr           = ptr_val;
        if (page_wr) s_d.page          = page_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ea         = op_direct ? {s_q.page, offset_in[OFF_W-1:0]} : cur_w;
    assign ar_rd_data = s_q.ar[ar_rd_sel];

    // R4: no-modify access keeps the current register
    p_nomod_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_en && (mod_code == 3'd0) && !ar_wr)
        |=> s_q.ar[$past(s_q.ptr)] == $past(cur_w));

    // R5: step by one upward
    p_inc1_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_en && (mod_code == 3'd1) && !ar_wr)
        |=> s_q.ar[$past(s_q.ptr)] == $past(cur_w) + W'(1));

    // R8: selector follows ptr_val one edge later
    p_ptr_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_wr |=> s_q.ptr == $past(ptr_val));

    // R9: explicit load always lands
    p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ar_wr |=> s_q.ar[$past(ar_wr_sel)] == $past(ar_wr_data));

    // R11: page-mode or idle cycles leave the register file alone
    p_direct_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!mod_en && !ar_wr) |=> s_q.ar == $past(s_q.ar));

    // R3: page changes only through page_wr
    p_page_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !page_wr |=> $stable(s_q.page));
endmodule

// File: tb/sim_aux_addr_gen.sv
module sim_aux_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0, op_direct = 1'b0;
    logic [2:0]  mod_code = '0;
    logic [6:0]  offset_in = '0;
    logic        ptr_wr = 1'b0;
    logic [2:0]  ptr_val = '0;
    logic        page_wr = 1'b0;
    logic [8:0]  page_val = '0;
    logic        ar_wr = 1'b0;
    logic [2:0]  ar_wr_sel = '0;
    logic [15:0] ar_wr_data = '0;
    logic [2:0]  ar_rd_sel = '0;
    logic [15:0] ar_rd_data, ea;

    always #2 clk = ~clk;

    aux_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_direct(op_direct),
        .mod_code(mod_code), .offset_in(offset_in), .ptr_wr(ptr_wr),
        .ptr_val(ptr_val), .page_wr(page_wr), .page_val(page_val),
        .ar_wr(ar_wr), .ar_wr_sel(ar_wr_sel), .ar_wr_data(ar_wr_data),
        .ar_rd_sel(ar_rd_sel), .ar_rd_data(ar_rd_data), .ea(ea)
    );

    typedef struct {
        logic [15:0] ea;
        logic [15:0] rd;
        bit          chk_ea;
        string       tag;
    } item_t;

    item_t       sb[$];
    int          n_chk = 0, n_fail = 0;
    logic [15:0] m_ar [8];
    logic [2:0]  m_ptr;
    logic [8:0]  m_page;

    function automatic logic [15:0] rc_step(input logic [15:0] a, input logic [15:0] b, input bit sub);
        logic [15:0] bb;
        logic [15:0] r;
        logic        c;
        bb = sub ? ~b : b;
        c  = sub;
        for (int i = 15; i >= 0; i--) begin
            r[i] = a[i] ^ bb[i] ^ c;
            c    = (a[i] & bb[i]) | (a[i] & c) | (bb[i] & c);
        end
        return r;
    endfunction

    task automatic cyc(input bit op, input bit dir, input logic [2:0] md, input logic [6:0] off,
                       input bit pw, input logic [2:0] pv, input bit aw, input logic [2:0] asel,
                       input logic [15:0] adat, input bit gw, input logic [8:0] gv,
                       input logic [2:0] rsel, input bit chk, input string tag);
        item_t       it;
        logic [15:0] cur, nx;
        @(negedge clk);
        op_valid = op; op_direct = dir; mod_code = md; offset_in = off;
        ptr_wr = pw; ptr_val = pv; ar_wr = aw; ar_wr_sel = asel; ar_wr_data = adat;
        page_wr = gw; page_val = gv; ar_rd_sel = rsel;
        cur = m_ar[m_ptr];
        it.ea = dir ? {m_page, off} : cur;
        it.rd = m_ar[rsel];
        it.chk_ea = chk;
        it.tag = tag;
        sb.push_back(it);
        case (md)
            3'd1: nx = cur + 16'd1;
            3'd2: nx = cur - 16'd1;
            3'd3: nx = cur + m_ar[0];
            3'd4: nx = cur - m_ar[0];
            3'd5: nx = rc_step(cur, m_ar[0], 1'b0);
            3'd6: nx = rc_step(cur, m_ar[0], 1'b1);
            default: nx = cur;
        endcase
        if (op && !dir) m_ar[m_ptr] = nx;
        if (aw) m_ar[asel] = adat;
        if (pw) m_ptr = pv;
        if (gw) m_page = gv;
    endtask

    task automatic idle(input logic [2:0] rsel, input string tag);
        cyc(0, 0, 3'd0, 7'd0, 0, 3'd0, 0, 3'd0, 16'd0, 0, 9'd0, rsel, 1, tag);
    endtask
    task automatic ld(input logic [2:0] r, input logic [15:0] v);
        cyc(0, 0, 3'd0, 7'd0, 0, 3'd0, 1, r, v, 0, 9'd0, r, 0, "R2");
    endtask
    task automatic setp(input logic [2:0] p);
        cyc(0, 0, 3'd0, 7'd0, 1, p, 0, 3'd0, 16'd0, 0, 9'd0, 3'd0, 0, "R8");
    endtask
    task automatic ind(input logic [2:0] md, input logic [2:0] rsel, input string tag);
        cyc(1, 0, md, 7'd0, 0, 3'd0, 0, 3'd0, 16'd0, 0, 9'd0, rsel, 1, tag);
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(negedge clk);
            #1;
            if (sb.size() > 0) begin
                it = sb.pop_front();
                n_chk++;
                if (ar_rd_data !== it.rd) begin
                    n_fail++;
                    $display("FAIL %s read: got %h expected %h", it.tag, ar_rd_data, it.rd);
                end
                if (it.chk_ea) begin
                    n_chk++;
                    if (ea !== it.ea) begin
                        n_fail++;
                        $display("FAIL %s ea: got %h expected %h", it.tag, ea, it.ea);
                    end
                end
            end
        end
    end

    initial begin : watchdog
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : driver
        for (int i = 0; i < 8; i++) m_ar[i] = '0;
        m_ptr = '0; m_page = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) idle(3'(i), "R1");
        ld(3'd0, 16'h0004); ld(3'd1, 16'h0100); ld(3'd2, 16'hFFFF);
        ld(3'd3, 16'h0000); ld(3'd5, 16'h1234);
        for (int i = 0; i < 6; i++) idle(3'(i), "R2");
        // R3: page write and access together; access sees old page
        cyc(1, 1, 3'd0, 7'h05, 0, 3'd0, 0, 3'd0, 16'd0, 1, 9'h1FF, 3'd0, 1, "R3");
        cyc(1, 1, 3'd0, 7'h7F, 0, 3'd0, 0, 3'd0, 16'd0, 1, 9'h006, 3'd0, 1, "R3");
        cyc(1, 1, 3'd0, 7'h00, 0, 3'd0, 0, 3'd0, 16'd0, 0, 9'd0, 3'd0, 1, "R3");
        // R11: page-mode access with a stepping code
        cyc(1, 1, 3'd1, 7'h11, 0, 3'd0, 0, 3'd0, 16'd0, 0, 9'd0, 3'd0, 1, "R11");
        cyc(0, 0, 3'd3, 7'h00, 0, 3'd0, 0, 3'd0, 16'd0, 0, 9'd0, 3'd0, 1, "R11");
        idle(3'd0, "R11");
        setp(3'd1);
        ind(3'd0, 3'd1, "R4"); ind(3'd7, 3'd1, "R4"); ind(3'd0, 3'd1, "R4");
        ind(3'd1, 3'd1, "R5"); ind(3'd1, 3'd1, "R5"); ind(3'd2, 3'd1, "R5");
        ind(3'd2, 3'd1, "R5"); idle(3'd1, "R5");
        setp(3'd2);
        ind(3'd1, 3'd2, "R10"); ind(3'd2, 3'd2, "R10"); ind(3'd2, 3'd2, "R10");
        idle(3'd2, "R10");
        setp(3'd1);
        ind(3'd3, 3'd1, "R6"); ind(3'd3, 3'd1, "R6"); ind(3'd4, 3'd1, "R6");
        setp(3'd0);
        ind(3'd3, 3'd0, "R6"); ind(3'd4, 3'd0, "R6"); idle(3'd0, "R6");
        ld(3'd0, 16'h0800);
        setp(3'd3);
        for (int i = 0; i < 5; i++) ind(3'd5, 3'd3, "R7");
        for (int i = 0; i < 6; i++) ind(3'd6, 3'd3, "R7");
        ld(3'd3, 16'h1230);
        ind(3'd5, 3'd3, "R7"); ind(3'd6, 3'd3, "R7"); idle(3'd3, "R7");
        // R8: access and selector change in one cycle
        cyc(1, 0, 3'd1, 7'd0, 1, 3'd5, 0, 3'd0, 16'd0, 0, 9'd0, 3'd3, 1, "R8");
        idle(3'd3, "R8");
        // R9: step and load hit the same register
        cyc(1, 0, 3'd1, 7'd0, 0, 3'd0, 1, 3'd5, 16'hAAAA, 0, 9'd0, 3'd5, 1, "R9");
        idle(3'd5, "R9");
        // R9: step and load to different registers
        cyc(1, 0, 3'd2, 7'd0, 0, 3'd0, 1, 3'd6, 16'h5555, 0, 9'd0, 3'd6, 1, "R9");
        idle(3'd6, "R9"); idle(3'd5, "R9");
        @(negedge clk);
        @(negedge clk);
        #2;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule